// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the 64-bit instruction address of a single-cycle processor and works out where the next fetch comes from. Each cycle it receives a two-bit target selector, an update enable, the instruction word now being executed and the zero status of the ALU. From these it either keeps the address, steps it by one instruction word, or adds a sign-extended word offset carried in the instruction.

Two relative forms exist. The long form takes a 26-bit offset from the bottom of the instruction and always loads. The short form takes a 19-bit offset that sits just above the 5-bit register field. It loads the branch target only when the zero test passes. Bit 24 of the instruction picks the polarity: 0 means branch on zero, 1 means branch on non-zero. A failed test falls through to the next sequential word, so the counter still advances.

The current address drives instruction fetch. The `pcNext` output shows the address that will be loaded at the coming clock edge. The return path for calls can tap it there.

Top module: `pc_sequencer`

## Requirements
- R1: A high `rst` sampled at a rising edge loads address 0, whatever the other inputs are.
- R2: With `pcSel` = 2'b01 and `pcEn` = 1, the address increases by 4 at the next edge.
- R3: With `pcSel` = 2'b00, the address keeps its value, whatever `pcEn`, `instr` or `zeroFlag` are.
- R4: With `pcSel` = 2'b10, the address becomes PC + 4 × signext(`instr[25:0]`). This happens even when `pcEn` is 0.
- R5: With `pcSel` = 2'b11, `pcEn` = 1 and `instr[24]` = 0, the address becomes PC + 4 × signext(`instr[23:5]`) when `zeroFlag` = 1. Otherwise it becomes PC + 4.
- R6: With `pcSel` = 2'b11, `pcEn` = 1 and `instr[24]` = 1, the address becomes PC + 4 × signext(`instr[23:5]`) when `zeroFlag` = 0. Otherwise it becomes PC + 4.
- R7: With `pcEn` = 0 and `pcSel` of 2'b01 or 2'b11, the address keeps its value.
- R8: When `rst` is low, `pcNext` equals the value `pcOut` takes after the next rising edge.
- R9: All address arithmetic wraps modulo 2^64. A negative offset from a low address yields a high address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pcSel | input | 2 | Target select: 00 hold, 01 step, 10 long branch, 11 compare branch |
| pcEn | input | 1 | Update enable (ignored for the long branch) |
| instr | input | 32 | Current instruction word (offset fields and bit 24 polarity) |
| zeroFlag | input | 1 | ALU zero status for compare branches |
| pcOut | output | 64 | Current program counter |
| pcNext | output | 64 | Address loaded at the next edge |

## Verification
Three functions can meet in one cycle.

- **Reset and a branch.** Reset can arrive while a long or short branch is selected. The bench drives exactly that and expects address 0 afterwards rather than the branch target.
- **Zero test and polarity.** The zero test and the polarity bit combine in the short form. All four combinations are driven from a known address, and the result is judged against either the target or the +4 fall-through.
- **Offset sign and wrap-around.** Offset sign extension and modulo wrap coincide when a negative offset is taken from address 0. This is provoked directly.

Random cycles then mix all of these, and are compared against a behavioural model every clock.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  localparam logic [1:0] SEL_HOLD  = 2'b00;
  localparam logic [1:0] SEL_STEP  = 2'b01;
  localparam logic [1:0] SEL_LONG  = 2'b10;
  localparam logic [1:0] SEL_SHORT = 2'b11;

  typedef enum logic [1:0] {
    SRC_KEEP,
    SRC_SEQ,
    SRC_FAR,
    SRC_NEAR
  } nextSrc_e;

  typedef struct packed {
    logic     loadEn;
    nextSrc_e src;
  } pcStrobe_t;

endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  pcSel,
  input  logic        pcEn,
  input  logic        condNonZero,
  input  logic        zeroFlag,
  output pcStrobe_t   strobe
);

  logic condPass;

  assign condPass = condNonZero ? ~zeroFlag : zeroFlag;

  always_comb begin
    strobe.loadEn = pcEn;
    strobe.src    = SRC_KEEP;
    unique case (pcSel)
      SEL_HOLD:  strobe.src = SRC_KEEP;
      SEL_STEP:  strobe.src = SRC_SEQ;
      SEL_LONG: begin
        strobe.src    = SRC_FAR;
        strobe.loadEn = 1'b1;
      end
      SEL_SHORT: strobe.src = condPass ? SRC_NEAR : SRC_SEQ;
      default:   strobe.src = SRC_KEEP;
    endcase
  end

  AST_LONG_FORCES_LOAD: assert property (@(posedge clk) disable iff (rst)
    (pcSel == SEL_LONG) |-> (strobe.loadEn && strobe.src == SRC_FAR)); // R4

  AST_NEAR_ONLY_ON_PASS: assert property (@(posedge clk) disable iff (rst)
    (strobe.src == SRC_NEAR) |-> (pcSel == SEL_SHORT && (zeroFlag ^ condNonZero))); // R5

endmodule

// File: rtl/pc_seq_datapath.sv
module pc_seq_datapath
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int FAR_W   = 26,
  parameter int NEAR_W  = 19,
  parameter int STEP    = 4,
  parameter int ALIGN   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  pcStrobe_t          strobe,
  input  logic [FAR_W-1:0]   farField,
  input  logic [NEAR_W-1:0]  nearField,
  output logic [ADDR_W-1:0]  pcOut,
  output logic [ADDR_W-1:0]  pcNext
);

  localparam int FAR_PAD  = ADDR_W - FAR_W;
  localparam int NEAR_PAD = ADDR_W - NEAR_W;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] farOff;
  logic [ADDR_W-1:0] nearOff;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] candidate;

  assign farOff  = {{FAR_PAD{farField[FAR_W-1]}}, farField} << ALIGN;
  assign nearOff = {{NEAR_PAD{nearField[NEAR_W-1]}}, nearField} << ALIGN;
  assign seqAddr = pcReg + ADDR_W'(STEP);

  always_comb begin
    unique case (strobe.src)
      SRC_SEQ:  candidate = seqAddr;
      SRC_FAR:  candidate = pcReg + farOff;
      SRC_NEAR: candidate = pcReg + nearOff;
      default:  candidate = pcReg;
    endcase
  end

  assign pcNext = strobe.loadEn ? candidate : pcReg;

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= pcNext;
  end

  assign pcOut = pcReg;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pcOut == '0)); // R1

  AST_NO_LOAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!strobe.loadEn || strobe.src == SRC_KEEP) |=> $stable(pcOut)); // R7

  AST_SEQ_ADDS_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadEn && strobe.src == SRC_SEQ) |=> (pcOut == $past(pcOut) + ADDR_W'(STEP))); // R2

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int INSTR_W  = 32,
  parameter int FAR_W    = 26,
  parameter int NEAR_W   = 19,
  parameter int NEAR_LSB = 5,
  parameter int COND_BIT = 24,
  parameter int STEP     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         pcSel,
  input  logic               pcEn,
  input  logic [INSTR_W-1:0] instr,
  input  logic               zeroFlag,
  output logic [ADDR_W-1:0]  pcOut,
  output logic [ADDR_W-1:0]  pcNext
);

  localparam int NEAR_MSB = NEAR_LSB + NEAR_W - 1;

  pcStrobe_t strobe;

  pc_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .pcSel       (pcSel),
    .pcEn        (pcEn),
    .condNonZero (instr[COND_BIT]),
    .zeroFlag    (zeroFlag),
    .strobe      (strobe)
  );

  pc_seq_datapath #(
    .ADDR_W (ADDR_W),
    .FAR_W  (FAR_W),
    .NEAR_W (NEAR_W),
    .STEP   (STEP)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .farField  (instr[FAR_W-1:0]),
    .nearField (instr[NEAR_MSB:NEAR_LSB]),
    .pcOut     (pcOut),
    .pcNext    (pcNext)
  );

  AST_NEXT_PREDICTS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pcOut == $past(pcNext))); // R8

  AST_HOLD_SELECT: assert property (@(posedge clk) disable iff (rst)
    (pcSel == SEL_HOLD) |=> $stable(pcOut)); // R3

  AST_INSTR_KNOWN: assert property (@(posedge clk) disable iff (rst)
    (pcSel != SEL_HOLD) |-> !$isunknown(instr)); // R4

endmodule

// File: tb/pc_sequencer_test.sv
`timescale 1ns/1ps
module pc_sequencer_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  pcSel;
  logic        pcEn;
  logic [31:0] instr;
  logic        zeroFlag;
  wire  [63:0] pcOut;
  wire  [63:0] pcNext;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit havePrev = 0;
  string prevTag = "R1";
  longint unsigned modelPc = 0;

  always #10 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst(rst), .pcSel(pcSel), .pcEn(pcEn),
    .instr(instr), .zeroFlag(zeroFlag), .pcOut(pcOut), .pcNext(pcNext)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned refNext(input longint unsigned pc, input logic [1:0] sel,
      input logic en, input logic [31:0] ins, input logic z, output string tag);
    longint farOff, nearOff;
    bit taken;
    farOff  = longint'($signed(ins[25:0])) * 4;
    nearOff = longint'($signed(ins[23:5])) * 4;
    case (sel)
      2'b00: begin tag = "R3"; return pc; end
      2'b01: begin tag = en ? "R2" : "R7"; return en ? pc + 4 : pc; end
      2'b10: begin tag = "R4"; return pc + farOff; end
      default: begin
        if (!en) begin tag = "R7"; return pc; end
        tag = ins[24] ? "R6" : "R5";
        taken = ins[24] ? !z : z;
        return taken ? pc + nearOff : pc + 4;
      end
    endcase
  endfunction

  task automatic step(input logic r, input logic [1:0] sel, input logic en,
      input logic [31:0] ins, input logic z);
    longint unsigned nxt;
    string tag;
    @(negedge clk);
    if (havePrev) check(prevTag, pcOut, modelPc);
    rst = r; pcSel = sel; pcEn = en; instr = ins; zeroFlag = z;
    #1;
    nxt = refNext(modelPc, sel, en, ins, z, tag);
    if (r) begin
      modelPc = 0;
      prevTag = "R1";
    end else begin
      check("R8", pcNext, nxt);
      modelPc = nxt;
      prevTag = tag;
    end
    havePrev = 1;
  endtask

  function automatic logic [31:0] mkFar(input int off);
    return {6'b000101, off[25:0]};
  endfunction

  function automatic logic [31:0] mkNear(input bit nonZero, input int off, input int rt);
    return {7'b1011010, nonZero, off[18:0], rt[4:0]};
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pcSel = 2'b00; pcEn = 1'b0; instr = '0; zeroFlag = 1'b0;
    step(1, 2'b01, 1, 32'h0, 0);
    step(1, 2'b10, 1, mkFar(100), 0);        // R1: reset beats a branch
    step(0, 2'b01, 1, 32'h8b000000, 0);      // R2
    step(0, 2'b01, 1, 32'h0, 1);             // R2
    step(0, 2'b00, 1, mkFar(50), 1);         // R3
    step(0, 2'b00, 0, mkNear(0, 9, 3), 1);   // R3
    step(0, 2'b10, 0, mkFar(16), 0);         // R4: enable ignored
    step(0, 2'b10, 1, mkFar(-6), 0);         // R4: backward
    step(0, 2'b11, 1, mkNear(0, 12, 7), 1);  // R5 taken
    step(0, 2'b11, 1, mkNear(0, 12, 7), 0);  // R5 fall-through
    step(0, 2'b11, 1, mkNear(1, -3, 2), 0);  // R6 taken
    step(0, 2'b11, 1, mkNear(1, -3, 2), 1);  // R6 fall-through
    step(0, 2'b01, 0, 32'h0, 0);             // R7
    step(0, 2'b11, 0, mkNear(0, 40, 1), 1);  // R7
    step(1, 2'b11, 1, mkNear(0, 40, 1), 1);  // R1 during compare branch
    step(0, 2'b10, 1, mkFar(-1), 0);         // R9: wrap below zero
    step(0, 2'b11, 1, mkNear(0, 2, 0), 1);   // R9: wrap above top
    for (int i = 0; i < 400; i++) begin
      step(($urandom_range(0, 31) == 0), 2'($urandom_range(0, 3)), 1'($urandom),
           $urandom, 1'($urandom));
    end
    @(negedge clk);
    check(prevTag, pcOut, modelPc);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule